// File: doc/BRIEF.md
# Priority Stage Dispatch Scheduler

This block decides which processing stage of a queue-connected graph gets to launch its next instance, and where that instance runs. Each stage owns a readiness flag, raised whenever one of its input packets arrives or one of its output packets is drained. The flag stays up until the scheduler looks at the stage and finds nothing it can do. Among flagged stages that have an input packet and free output room, the stage with the highest configured priority wins. Its input and output are reserved in the same pulse that launches it. Priorities are meant to rise toward the sink end of the graph, so that downstream work drains before upstream work grows.

The chosen instance is placed on the core with the fewest busy thread slots, in the lowest-numbered free slot of that core. The block remembers which stage owns each slot. When an instance finishes, the block emits a commit for that stage and frees the slot, so the slot can be refilled on a later decision. The queues and the cores lie outside this block. They report packet levels and completions as inputs, and they act on the reserve and commit pulses.

Top module: `stage_dispatch_sched`

## Requirements
- R1: After reset, `disp_valid`, `cmt_valid` and all `inspect_bits` are 0, every slot is free, and each stage's priority equals its own stage index.
- R2: A 1 on `in_arrive[s]` or `out_consumed[s]` during a cycle makes `inspect_bits[s]` read 1 after that clock edge. A set and a clear in the same cycle resolve to set.
- R3: A stage is a candidate when its inspect bit, `in_avail` and `out_space` are all 1. The dispatched stage is the candidate with the largest priority value. Equal values go to the lower stage index. `cfg_we` writes `cfg_prio` as the priority of stage `cfg_stage`.
- R4: On any edge where at least one slot is free, every flagged stage lacking `in_avail` or `out_space` has its inspect bit cleared. The bit of a stage that is dispatched stays set.
- R5: A decision on one edge shows as a one-cycle `disp_valid` pulse after that edge. The pulse carries stage, core and slot, and it is the reserve request for that stage's input packet and output space. The stage just dispatched is neither chosen nor cleared on the very next edge.
- R6: The core is the one with the fewest occupied slots among those that have a free slot, with ties going to the lower core index. The slot is the lowest-numbered free slot on that core.
- R7: `done_valid` naming an occupied slot frees it. After that edge, `cmt_valid` pulses with the owning stage, core and slot.
- R8: `done_valid` naming a free slot changes nothing, and no commit follows.
- R9: While all slots are occupied there is no dispatch, and inspect bits keep their value. Once a slot frees, dispatch resumes into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Priority write strobe |
| cfg_stage | input | 3 | Stage whose priority is written |
| cfg_prio | input | 4 | Priority value to write (larger wins) |
| in_arrive | input | 8 | Per-stage pulse: new input packet arrived |
| out_consumed | input | 8 | Per-stage pulse: an output packet was drained |
| in_avail | input | 8 | Per-stage level: an input packet is available |
| out_space | input | 8 | Per-stage level: output space is free |
| done_valid | input | 1 | Instance completion strobe |
| done_core | input | 2 | Core of the completed instance |
| done_slot | input | 5 | Slot of the completed instance |
| disp_valid | output | 1 | Dispatch and reserve pulse |
| disp_stage | output | 3 | Stage dispatched |
| disp_core | output | 2 | Core chosen |
| disp_slot | output | 5 | Slot chosen |
| cmt_valid | output | 1 | Commit pulse for a completed instance |
| cmt_stage | output | 3 | Stage whose input and output are committed |
| cmt_core | output | 2 | Core of the freed slot |
| cmt_slot | output | 5 | Freed slot |
| inspect_bits | output | 8 | Current per-stage inspect flags |

## Verification
The bench builds the block with its defaults: eight stages, four cores of 24 slots, and 4-bit priorities. At that size all 96 slots can be filled in a few hundred cycles, which puts the full-machine stall and the refill of one freed slot within reach. The narrow priority field makes a deliberate tie easy to set up. Four cores make the least-loaded rotation and its tie rule visible over several consecutive dispatches.

// File: rtl/sched_pkg.sv
package sched_pkg;

  // Number of set bits in a word (slot occupancy count).
  function automatic int unsigned ones32(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) if (v[i]) n++;
    return n;
  endfunction

  // Position of the lowest clear bit (first free slot), 32 when none.
  function automatic int unsigned first_zero32(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (!v[i]) return i;
    return 32;
  endfunction

endpackage

// File: rtl/sched_inspect.sv
module sched_inspect #(
  parameter int NS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] set_ev,
  input  logic [NS-1:0] clr,
  output logic [NS-1:0] inspect_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) inspect_q <= '0;
    else        inspect_q <= (inspect_q & ~clr) | set_ev;
  end

  // R2: an event always leaves the flag raised after the edge
  p_set_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_ev) |=> ((inspect_q & $past(set_ev)) == $past(set_ev)));

endmodule

// File: rtl/sched_prio_sel.sv
module sched_prio_sel #(
  parameter int NS = 8,
  parameter int PW = 4,
  localparam int SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_stage,
  input  logic [PW-1:0] cfg_prio,
  input  logic [NS-1:0] cand,
  output logic          pick_valid,
  output logic [SW-1:0] pick_stage
);

  logic [PW-1:0] prio [NS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) prio[i] <= PW'(i);
    end else if (cfg_we) begin
      prio[cfg_stage] <= cfg_prio;
    end
  end

  // Scan upward; only a strictly larger value replaces, so ties keep the lower index.
  always_comb begin
    logic [PW-1:0] best_p;
    pick_valid = 1'b0;
    pick_stage = '0;
    best_p     = '0;
    for (int i = 0; i < NS; i++) begin
      if (cand[i] && (!pick_valid || prio[i] > best_p)) begin
        pick_valid = 1'b1;
        pick_stage = SW'(i);
        best_p     = prio[i];
      end
    end
  end

  // R3: the pick is always one of the candidates
  p_pick_is_cand_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> cand[pick_stage]);

endmodule

// File: rtl/sched_slot_pool.sv
module sched_slot_pool
  import sched_pkg::*;
#(
  parameter int NC    = 4,
  parameter int NSLOT = 24,
  parameter int NS    = 8,
  localparam int CW = $clog2(NC),
  localparam int LW = $clog2(NSLOT),
  localparam int SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic [SW-1:0] alloc_stage,
  input  logic          done_valid,
  input  logic [CW-1:0] done_core,
  input  logic [LW-1:0] done_slot,
  output logic          any_free,
  output logic [CW-1:0] pick_core,
  output logic [LW-1:0] pick_slot,
  output logic          done_hit,
  output logic [SW-1:0] done_stage
);

  logic [NSLOT-1:0] occ     [NC];
  logic [NSLOT-1:0] occ_nxt [NC];
  logic [SW-1:0]    owner   [NC][NSLOT];
  logic             slot_ok;

  // Least-loaded core that still has room, then its lowest free slot.
  always_comb begin
    int unsigned best_l;
    any_free  = 1'b0;
    pick_core = '0;
    best_l    = NSLOT;
    for (int c = 0; c < NC; c++) begin
      int unsigned l;
      l = ones32(32'(occ[c]));
      if (l < NSLOT && (!any_free || l < best_l)) begin
        any_free  = 1'b1;
        pick_core = CW'(c);
        best_l    = l;
      end
    end
    pick_slot = LW'(first_zero32(32'(occ[pick_core])));
  end

  assign slot_ok    = int'(done_slot) < NSLOT;
  assign done_hit   = done_valid && slot_ok && occ[done_core][done_slot];
  assign done_stage = owner[done_core][done_slot];

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      occ_nxt[c] = occ[c];
      if (done_hit && done_core == CW'(c)) occ_nxt[c][done_slot] = 1'b0;
      if (alloc_valid && pick_core == CW'(c)) occ_nxt[c][pick_slot] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) occ[c] <= '0;
    end else begin
      for (int c = 0; c < NC; c++) occ[c] <= occ_nxt[c];
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_valid) owner[pick_core][pick_slot] <= alloc_stage;
  end

  // R6: an allocation never targets an occupied slot
  p_alloc_free_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> (any_free && !occ[pick_core][pick_slot]));

  // R6: the allocated slot reads busy on the following cycle
  p_alloc_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> occ[$past(pick_core)][$past(pick_slot)]);

  // R9: a full machine allows no allocation
  p_full_no_alloc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_free |-> !alloc_valid);

endmodule

// File: rtl/stage_dispatch_sched.sv
module stage_dispatch_sched #(
  parameter int NUM_STAGES = 8,
  parameter int NUM_CORES  = 4,
  parameter int SLOTS      = 24,
  parameter int PRIO_W     = 4,
  localparam int SW = $clog2(NUM_STAGES),
  localparam int CW = $clog2(NUM_CORES),
  localparam int LW = $clog2(SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [SW-1:0]         cfg_stage,
  input  logic [PRIO_W-1:0]     cfg_prio,
  input  logic [NUM_STAGES-1:0] in_arrive,
  input  logic [NUM_STAGES-1:0] out_consumed,
  input  logic [NUM_STAGES-1:0] in_avail,
  input  logic [NUM_STAGES-1:0] out_space,
  input  logic                  done_valid,
  input  logic [CW-1:0]         done_core,
  input  logic [LW-1:0]         done_slot,
  output logic                  disp_valid,
  output logic [SW-1:0]         disp_stage,
  output logic [CW-1:0]         disp_core,
  output logic [LW-1:0]         disp_slot,
  output logic                  cmt_valid,
  output logic [SW-1:0]         cmt_stage,
  output logic [CW-1:0]         cmt_core,
  output logic [LW-1:0]         cmt_slot,
  output logic [NUM_STAGES-1:0] inspect_bits
);

  logic [NUM_STAGES-1:0] inspect_q, runnable, hold_mask, cand, clr_vec, set_vec;
  logic                  pick_valid, any_free, dispatch, done_hit;
  logic [SW-1:0]         pick_stage, done_stage;
  logic [CW-1:0]         pick_core;
  logic [LW-1:0]         pick_slot;

  assign runnable  = in_avail & out_space;
  // The stage reserved last cycle sits out one edge while its queue levels settle.
  assign hold_mask = disp_valid ? (NUM_STAGES'(1) << disp_stage) : '0;
  assign cand      = inspect_q & runnable & ~hold_mask;
  assign clr_vec   = any_free ? (inspect_q & ~runnable & ~hold_mask) : '0;
  assign set_vec   = in_arrive | out_consumed;
  assign dispatch  = any_free & pick_valid;

  sched_inspect #(.NS(NUM_STAGES)) u_inspect (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_ev    (set_vec),
    .clr       (clr_vec),
    .inspect_q (inspect_q)
  );

  sched_prio_sel #(.NS(NUM_STAGES), .PW(PRIO_W)) u_prio (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_stage  (cfg_stage),
    .cfg_prio   (cfg_prio),
    .cand       (cand),
    .pick_valid (pick_valid),
    .pick_stage (pick_stage)
  );

  sched_slot_pool #(.NC(NUM_CORES), .NSLOT(SLOTS), .NS(NUM_STAGES)) u_pool (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (dispatch),
    .alloc_stage (pick_stage),
    .done_valid  (done_valid),
    .done_core   (done_core),
    .done_slot   (done_slot),
    .any_free    (any_free),
    .pick_core   (pick_core),
    .pick_slot   (pick_slot),
    .done_hit    (done_hit),
    .done_stage  (done_stage)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_valid <= 1'b0;
      disp_stage <= '0;
      disp_core  <= '0;
      disp_slot  <= '0;
      cmt_valid  <= 1'b0;
      cmt_stage  <= '0;
      cmt_core   <= '0;
      cmt_slot   <= '0;
    end else begin
      disp_valid <= dispatch;
      disp_stage <= pick_stage;
      disp_core  <= pick_core;
      disp_slot  <= pick_slot;
      cmt_valid  <= done_hit;
      cmt_stage  <= done_stage;
      cmt_core   <= done_core;
      cmt_slot   <= done_slot;
    end
  end

  assign inspect_bits = inspect_q;

  // R3: a dispatch pulse names a stage that was flagged and runnable
  p_disp_from_cand_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ((($past(inspect_q & runnable)) >> disp_stage) & NUM_STAGES'(1)) != '0);

  // R5: no stage is dispatched on two consecutive edges
  p_no_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !(disp_valid && disp_stage == $past(disp_stage)));

  // R7: a commit only follows a completion strobe
  p_cmt_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> $past(done_valid));

endmodule

// File: tb/stage_dispatch_sched_tb_top.sv
module stage_dispatch_sched_tb_top;

  localparam int NS = 8, NC = 4, NSL = 24;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [2:0] cfg_stage;
  logic [3:0] cfg_prio;
  logic [7:0] in_arrive, out_consumed, in_avail, out_space;
  logic       done_valid;
  logic [1:0] done_core;
  logic [4:0] done_slot;
  logic       disp_valid, cmt_valid;
  logic [2:0] disp_stage, cmt_stage;
  logic [1:0] disp_core, cmt_core;
  logic [4:0] disp_slot, cmt_slot;
  logic [7:0] inspect_bits;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  ended  = 0;
  bit  occ_b [NC][NSL];

  always #2 clk = ~clk;  // 250 MHz

  stage_dispatch_sched dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_stage(cfg_stage), .cfg_prio(cfg_prio),
    .in_arrive(in_arrive), .out_consumed(out_consumed), .in_avail(in_avail), .out_space(out_space),
    .done_valid(done_valid), .done_core(done_core), .done_slot(done_slot),
    .disp_valid(disp_valid), .disp_stage(disp_stage), .disp_core(disp_core), .disp_slot(disp_slot),
    .cmt_valid(cmt_valid), .cmt_stage(cmt_stage), .cmt_core(cmt_core), .cmt_slot(cmt_slot),
    .inspect_bits(inspect_bits)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Where the next instance should land, from the bench's own occupancy record.
  task automatic expect_place(output int ec, output int es);
    int best = NSL + 1;
    ec = -1; es = -1;
    for (int c = 0; c < NC; c++) begin
      int busy = 0;
      for (int s = 0; s < NSL; s++) busy += occ_b[c][s] ? 1 : 0;
      if (busy < NSL && busy < best) begin best = busy; ec = c; end
    end
    if (ec >= 0)
      for (int s = NSL - 1; s >= 0; s--) if (!occ_b[ec][s]) es = s;
  endtask

  task automatic check_disp(string req, int exp_stage);
    int ec, es;
    expect_place(ec, es);
    chk(req, "disp_valid", int'(disp_valid), 1);
    chk(req, "disp_stage", int'(disp_stage), exp_stage);
    chk("R6", "disp_core", int'(disp_core), ec);
    chk("R6", "disp_slot", int'(disp_slot), es);
    if (disp_valid) occ_b[disp_core][disp_slot] = 1;
  endtask

  task automatic cfg(int st, int p);
    cfg_we = 1; cfg_stage = 3'(st); cfg_prio = 4'(p);
    tick();
    cfg_we = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; cfg_we = 0; cfg_stage = 0; cfg_prio = 0;
    in_arrive = 0; out_consumed = 0; in_avail = 0; out_space = 8'hFF;
    done_valid = 0; done_core = 0; done_slot = 0;
    repeat (4) tick();
    rst_n = 1;
    tick();
    chk("R1", "disp_valid", int'(disp_valid), 0);
    chk("R1", "cmt_valid", int'(cmt_valid), 0);
    chk("R1", "inspect_bits", int'(inspect_bits), 0);
  endtask

  // Two stages flagged together; first and second show the priority order.
  task automatic t_race(string req, int sa, int sb, int first, int second);
    in_avail[sa] = 1; in_avail[sb] = 1;
    in_arrive[sa] = 1; in_arrive[sb] = 1;
    tick();
    in_arrive = 0;
    chk("R2", "both flags raised", int'(inspect_bits[sa] & inspect_bits[sb]), 1);
    tick();
    check_disp(req, first);
    in_avail[first] = 0;
    tick();
    check_disp(req, second);
    in_avail[second] = 0;
    tick(); tick();
    chk("R4", "flags cleared once drained", int'(inspect_bits), 0);
  endtask

  task automatic t_not_runnable();
    // no input: flag rises then clears, nothing launched
    in_arrive[7] = 1;
    tick();
    in_arrive = 0;
    chk("R2", "arrival sets flag", int'(inspect_bits[7]), 1);
    tick();
    chk("R4", "no input clears flag", int'(inspect_bits[7]), 0);
    chk("R4", "no dispatch", int'(disp_valid), 0);
    // input but no output room
    in_avail[7] = 1; out_space[7] = 0; in_arrive[7] = 1;
    tick();
    in_arrive = 0;
    tick();
    chk("R4", "no output room clears flag", int'(inspect_bits[7]), 0);
    chk("R4", "no dispatch without room", int'(disp_valid), 0);
    // room appears via a drained output packet
    out_space[7] = 1; out_consumed[7] = 1;
    tick();
    out_consumed = 0;
    chk("R2", "consumption sets flag", int'(inspect_bits[7]), 1);
    tick();
    check_disp("R3", 7);
    in_avail[7] = 0;
    tick(); tick();
  endtask

  task automatic t_done_free_slot();
    done_valid = 1; done_core = 3; done_slot = 20;
    tick();
    done_valid = 0;
    chk("R8", "no commit for free slot", int'(cmt_valid), 0);
    tick();
    chk("R8", "still no commit", int'(cmt_valid), 0);
  endtask

  task automatic t_complete(int c, int s, int exp_stage);
    done_valid = 1; done_core = 2'(c); done_slot = 5'(s);
    tick();
    done_valid = 0;
    chk("R7", "cmt_valid", int'(cmt_valid), 1);
    chk("R7", "cmt_stage", int'(cmt_stage), exp_stage);
    chk("R7", "cmt_core", int'(cmt_core), c);
    chk("R7", "cmt_slot", int'(cmt_slot), s);
    occ_b[c][s] = 0;
    tick();
    chk("R7", "single commit pulse", int'(cmt_valid), 0);
  endtask

  task automatic t_fill(string req, int st, int n);
    int got = 0;
    int guard = 0;
    in_avail[st] = 1; in_arrive[st] = 1;
    tick();
    in_arrive = 0;
    while (got < n && guard < 2000) begin
      tick();
      guard++;
      if (disp_valid) begin
        check_disp(req, st);
        got++;
        if (got == n) in_avail[st] = 0;
      end
    end
    chk(req, "dispatch count", got, n);
    tick(); tick();
  endtask

  task automatic t_full_stall();
    int busy = 0;
    int seen = 0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NSL; s++) busy += occ_b[c][s] ? 1 : 0;
    t_fill("R6", 0, NC * NSL - busy);
    in_avail[2] = 1; in_arrive[2] = 1;
    tick();
    in_arrive = 0;
    for (int k = 0; k < 6; k++) begin
      tick();
      seen += disp_valid ? 1 : 0;
    end
    chk("R9", "no dispatch while full", seen, 0);
    chk("R9", "flag held while full", int'(inspect_bits[2]), 1);
    done_valid = 1; done_core = 2; done_slot = 5;
    tick();
    done_valid = 0;
    chk("R7", "commit on full machine", int'(cmt_valid), 1);
    occ_b[2][5] = 0;
    seen = 0;
    for (int k = 0; k < 4 && !seen; k++) begin
      tick();
      if (disp_valid) begin
        seen = 1;
        chk("R9", "refill stage", int'(disp_stage), 2);
        chk("R9", "refill core", int'(disp_core), 2);
        chk("R9", "refill slot", int'(disp_slot), 5);
      end
    end
    chk("R9", "refill happened", seen, 1);
    in_avail[2] = 0;
    tick(); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      report();
    end
  end

  initial begin
    t_reset();
    t_done_free_slot();                   // R8
    t_race("R1", 1, 4, 4, 1);             // default priority = index
    cfg(3, 9); cfg(5, 12);
    t_race("R3", 3, 5, 5, 3);             // configured priority wins
    cfg(6, 7); cfg(1, 7);
    t_race("R3", 6, 1, 1, 6);             // tie goes to lower index
    t_not_runnable();                     // R2, R4
    t_fill("R5", 4, 6);                   // rotation across cores
    t_complete(0, 0, 4);                  // R7: core0 slot0 held stage 4
    t_fill("R6", 2, 1);                   // freed slot refilled first
    t_full_stall();                       // R9
    report();
  end

endmodule